// File: doc/BRIEF.md
# Board Control Register Bank

This block is a 32-bit register bank that sits behind a simple APB-style slave port and decodes a 4 KB window. It holds two general configuration words and three fixed identification words. The low byte of one configuration word drives eight LED outputs. The bank also has a status and mask word for eight delay-locked-loop lock inputs, and a small array of oscillator frequency registers. Their current values are driven out of the block on a flat output bus.

Software cannot address the oscillator array directly. It reaches the array through an indirect channel. It first loads an outgoing data word, then writes a control word that names a function code and a device index. Setting the go bit in that control word runs a read or a write at once. The result lands in a returned-data word, and two status flags report done and error. A request is legal only when the function code is 1 and the device index is below the oscillator count. An illegal request raises error together with done and modifies nothing.

Bus accesses take a single cycle with no wait states. Only word-aligned addresses decode. Every other address reads as zero and ignores writes.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset, the registers read as follows. Control word (0x0A8) is 0x00100000. DLL word (0x100) is 0xFFFF0001 when all eight lock inputs are high. Config words 0x000 and 0x004, returned data (0x0A0), outgoing data (0x0A4) and status (0x0AC) are 0. Oscillator k holds its reset parameter (50000000, 24576000 and 25000000 by default). led_o is 0.
- R2: Offset 0x00C always reads zero. Offsets 0x010, 0xFF8 and 0xFFC return the CFG4_VAL, AID_VAL and ID_VAL parameters.
- R3: A read of any offset not listed in R1 or R2 returns zero, and so does a read with paddr_i[1:0] nonzero. Writes to such offsets, or to 0x00C, 0x010, 0x0A0, 0x0AC, 0xFF8 and 0xFFC, change no register and no output.
- R4: Offsets 0x000 and 0x004 are fully writable 32-bit words. led_o equals bits [7:0] of the word at 0x004 from the cycle after the write.
- R5: The control word stores only device index [11:0], function code [25:20] and write flag [30]. Bits [19:12], [29:26] and the go bit [31] always read back as zero.
- R6: Every write to the control word first clears both status bits: done is bit 0 and error is bit 1. Bits [31:2] of status always read zero.
- R7: A control write with bit 31 set sets done. If the request is valid and bit 30 is set, the outgoing data word is copied into oscillator[device], and osc_o shows it from the next cycle.
- R8: A valid control write with bit 31 set and bit 30 clear copies oscillator[device] into the returned data word.
- R9: If the function code is not 1, or the device index is not below NUM_OSC, a go request sets status to 0b11. The oscillators and the returned data word stay unchanged.
- R10: In the DLL word, only bits [31:24] are writable; they hold the lock mask, which resets to 0xFF. Bits [23:16] show the lock inputs as they are now. Bit 0 is 1 exactly when every lock input selected by a 1 in the mask is high. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte offset within the window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, combinational during a selected read |
| dll_locked_i | input | NUM_DLL | Per-loop lock status |
| led_o | output | 8 | LED drive |
| osc_o | output | 32*NUM_OSC | Current oscillator values, oscillator k in bits [32k+31:32k] |

## Verification
Two functions can meet in the same clock edge: a write that changes the DLL lock mask, and a change of the lock inputs. The bench switches dll_locked_i in the same cycle as the access phase of a mask write. It does this for every one of the 256 mask values, with several lock patterns. It then reads the DLL word and checks the combined lock bit against a value computed in the bench from the new mask and the new inputs. Neither the stale mask nor the stale inputs may leak into the result.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_CFG0 = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CFG1 = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CFG3 = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_CFG4 = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_RTN  = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFS_OUT  = 12'h0A4;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h0A8;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h0AC;
  localparam logic [ADDR_W-1:0] OFS_DLL  = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_AID  = 12'hFF8;
  localparam logic [ADDR_W-1:0] OFS_ID   = 12'hFFC;

  // channel control word layout
  localparam int CTRL_DEV_LSB  = 0;
  localparam int CTRL_DEV_W    = 12;
  localparam int CTRL_FUNC_LSB = 20;
  localparam int CTRL_FUNC_W   = 6;
  localparam int CTRL_WR_BIT   = 30;
  localparam int CTRL_GO_BIT   = 31;
  localparam logic [31:0] CTRL_KEEP  = 32'h43F0_0FFF;
  localparam logic [31:0] CTRL_RESET = 32'h0010_0000;

  localparam int DLL_MASK_LSB = 24;
  localparam int DLL_LOCK_LSB = 16;
  localparam int DLL_FIELD_W  = 8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG0, SEL_CFG1, SEL_CFG3, SEL_CFG4, SEL_RTN,
    SEL_OUT, SEL_CTRL, SEL_STAT, SEL_DLL, SEL_AID, SEL_ID
  } reg_sel_e;

  typedef struct packed {
    logic [31:0] rtn;
    logic [31:0] out;
    logic [31:0] ctrl;
    logic [1:0]  stat;
  } chan_view_t;

endpackage

// File: rtl/board_ctrl_decode.sv
module board_ctrl_decode
  import board_ctrl_pkg::*;
(
  input  logic [ADDR_W-1:0] paddr_i,
  output reg_sel_e          sel_o
);
  // offsets are all word aligned, so a misaligned address falls to SEL_NONE
  always_comb begin
    case (paddr_i)
      OFS_CFG0: sel_o = SEL_CFG0;
      OFS_CFG1: sel_o = SEL_CFG1;
      OFS_CFG3: sel_o = SEL_CFG3;
      OFS_CFG4: sel_o = SEL_CFG4;
      OFS_RTN:  sel_o = SEL_RTN;
      OFS_OUT:  sel_o = SEL_OUT;
      OFS_CTRL: sel_o = SEL_CTRL;
      OFS_STAT: sel_o = SEL_STAT;
      OFS_DLL:  sel_o = SEL_DLL;
      OFS_AID:  sel_o = SEL_AID;
      OFS_ID:   sel_o = SEL_ID;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/board_ctrl_dll.sv
module board_ctrl_dll
  import board_ctrl_pkg::*;
#(
  parameter int NUM_DLL = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_DLL-1:0] mask_wdata_i,
  input  logic [NUM_DLL-1:0] locked_i,
  output logic [31:0]        word_o
);
  logic [NUM_DLL-1:0] mask_q;
  logic               all_locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (wr_i) mask_q <= mask_wdata_i;
  end

  // masked-out loops count as locked
  assign all_locked = &(locked_i | ~mask_q);

  assign word_o = {DLL_FIELD_W'(mask_q), DLL_FIELD_W'(locked_i), 15'b0, all_locked};
endmodule

// File: rtl/board_ctrl_osc_chan.sv
module board_ctrl_osc_chan
  import board_ctrl_pkg::*;
#(
  parameter int                     NUM_OSC    = 3,
  parameter logic [NUM_OSC*32-1:0]  OSC_RESET  = '0,
  parameter logic [CTRL_FUNC_W-1:0] VALID_FUNC = 6'd1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_out_i,
  input  logic                  wr_ctrl_i,
  input  logic [31:0]           wdata_i,
  output chan_view_t            view_o,
  output logic [NUM_OSC*32-1:0] osc_o
);
  localparam logic [CTRL_DEV_W-1:0] DEV_LIMIT = CTRL_DEV_W'(NUM_OSC);

  logic [31:0] rtn_q, out_q, ctrl_q;
  logic [1:0]  stat_q;
  logic [31:0] osc_q [NUM_OSC];
  logic [31:0] osc_sel;

  logic [CTRL_DEV_W-1:0]  req_dev;
  logic [CTRL_FUNC_W-1:0] req_func;
  logic                   req_wr, req_go, req_ok;

  assign req_dev  = wdata_i[CTRL_DEV_LSB +: CTRL_DEV_W];
  assign req_func = wdata_i[CTRL_FUNC_LSB +: CTRL_FUNC_W];
  assign req_wr   = wdata_i[CTRL_WR_BIT];
  assign req_go   = wdata_i[CTRL_GO_BIT] & wr_ctrl_i;
  assign req_ok   = (req_func == VALID_FUNC) && (req_dev < DEV_LIMIT);

  always_comb begin
    osc_sel = '0;
    for (int k = 0; k < NUM_OSC; k++)
      if (req_dev == CTRL_DEV_W'(k)) osc_sel = osc_q[k];
  end

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        osc_q[g] <= OSC_RESET[g*32 +: 32];
      else if (req_go && req_ok && req_wr && req_dev == CTRL_DEV_W'(g))
        osc_q[g] <= out_q;
    end
    assign osc_o[g*32 +: 32] = osc_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rtn_q  <= '0;
      out_q  <= '0;
      ctrl_q <= CTRL_RESET;
      stat_q <= '0;
    end else begin
      if (wr_out_i) out_q <= wdata_i;
      if (wr_ctrl_i) begin
        ctrl_q <= wdata_i & CTRL_KEEP;
        stat_q <= req_go ? {~req_ok, 1'b1} : 2'b00;
      end
      if (req_go && req_ok && !req_wr) rtn_q <= osc_sel;
    end
  end

  assign view_o = '{rtn: rtn_q, out: out_q, ctrl: ctrl_q, stat: stat_q};
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter int                     NUM_OSC    = 3,
  parameter logic [NUM_OSC*32-1:0]  OSC_RESET  = {32'd25000000, 32'd24576000, 32'd50000000},
  parameter int                     NUM_DLL    = 8,
  parameter logic [CTRL_FUNC_W-1:0] VALID_FUNC = 6'd1,
  parameter logic [31:0]            CFG4_VAL   = 32'h0000_0000,
  parameter logic [31:0]            AID_VAL    = 32'h0000_0000,
  parameter logic [31:0]            ID_VAL     = 32'h0000_0000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  psel_i,
  input  logic                  penable_i,
  input  logic                  pwrite_i,
  input  logic [ADDR_W-1:0]     paddr_i,
  input  logic [31:0]           pwdata_i,
  output logic [31:0]           prdata_o,
  input  logic [NUM_DLL-1:0]    dll_locked_i,
  output logic [7:0]            led_o,
  output logic [NUM_OSC*32-1:0] osc_o
);
  reg_sel_e    sel;
  logic        wr_en;
  logic [31:0] cfg0_q, cfg1_q, dll_word, rdata;
  chan_view_t  chan;
  logic [1:0]  chan_stat;
  logic [31:0] chan_rtn;

  board_ctrl_decode i_decode (
    .paddr_i (paddr_i),
    .sel_o   (sel)
  );

  assign wr_en = psel_i & penable_i & pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CFG0) cfg0_q <= pwdata_i;
      if (sel == SEL_CFG1) cfg1_q <= pwdata_i;
    end
  end

  board_ctrl_osc_chan #(
    .NUM_OSC    (NUM_OSC),
    .OSC_RESET  (OSC_RESET),
    .VALID_FUNC (VALID_FUNC)
  ) i_chan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_out_i  (wr_en && sel == SEL_OUT),
    .wr_ctrl_i (wr_en && sel == SEL_CTRL),
    .wdata_i   (pwdata_i),
    .view_o    (chan),
    .osc_o     (osc_o)
  );

  assign chan_stat = chan.stat;
  assign chan_rtn  = chan.rtn;

  board_ctrl_dll #(
    .NUM_DLL (NUM_DLL)
  ) i_dll (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_en && sel == SEL_DLL),
    .mask_wdata_i (pwdata_i[DLL_MASK_LSB +: NUM_DLL]),
    .locked_i     (dll_locked_i),
    .word_o       (dll_word)
  );

  always_comb begin
    case (sel)
      SEL_CFG0: rdata = cfg0_q;
      SEL_CFG1: rdata = cfg1_q;
      SEL_CFG4: rdata = CFG4_VAL;
      SEL_RTN:  rdata = chan.rtn;
      SEL_OUT:  rdata = chan.out;
      SEL_CTRL: rdata = chan.ctrl;
      SEL_STAT: rdata = {30'b0, chan.stat};
      SEL_DLL:  rdata = dll_word;
      SEL_AID:  rdata = AID_VAL;
      SEL_ID:   rdata = ID_VAL;
      default:  rdata = '0;
    endcase
  end

  assign prdata_o = (psel_i && !pwrite_i) ? rdata : '0;
  assign led_o    = cfg1_q[7:0];
endmodule

// File: rtl/board_ctrl_regs_chk.sv
module board_ctrl_regs_chk
  import board_ctrl_pkg::*;
#(
  parameter int NUM_OSC = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  psel_i,
  input logic                  penable_i,
  input logic                  pwrite_i,
  input logic [ADDR_W-1:0]     paddr_i,
  input logic [31:0]           pwdata_i,
  input logic [31:0]           prdata_o,
  input logic [7:0]            led_o,
  input logic [NUM_OSC*32-1:0] osc_o,
  input logic [1:0]            stat_i,
  input logic [31:0]           rtn_i
);
  logic wr, rd, ctrl_wr, bad_go;
  assign wr      = psel_i && penable_i && pwrite_i;
  assign rd      = psel_i && !pwrite_i;
  assign ctrl_wr = wr && paddr_i == OFS_CTRL;
  assign bad_go  = ctrl_wr && pwdata_i[31] &&
                   (pwdata_i[25:20] != 6'd1 || 32'(pwdata_i[11:0]) >= NUM_OSC);

  AST_LED_TRACKS_CFG1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && paddr_i == OFS_CFG1 |=> led_o == $past(pwdata_i[7:0])); // R4
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && paddr_i == OFS_CTRL |-> (prdata_o & ~CTRL_KEEP) == 32'b0); // R5
  AST_CTRL_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !pwdata_i[31] |=> stat_i == 2'b00); // R6
  AST_STAT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && paddr_i == OFS_STAT |-> prdata_o[31:2] == 30'b0); // R6
  AST_GO_SETS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && pwdata_i[31] |=> stat_i[0]); // R7
  AST_BAD_GO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_go |=> stat_i == 2'b11); // R9
  AST_BAD_GO_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_go |=> $stable(osc_o) && $stable(rtn_i)); // R9
  AST_MISALIGNED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && paddr_i[1:0] != 2'b00 |-> prdata_o == 32'b0); // R3
endmodule

bind board_ctrl_regs board_ctrl_regs_chk #(.NUM_OSC(NUM_OSC)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .pwdata_i  (pwdata_i),
  .prdata_o  (prdata_o),
  .led_o     (led_o),
  .osc_o     (osc_o),
  .stat_i    (chan_stat),
  .rtn_i     (chan_rtn)
);

// File: tb/test_board_ctrl_regs.sv
`timescale 1ns/1ps
module test_board_ctrl_regs;
  localparam int NOSC = 3;
  localparam logic [31:0] P_CFG4 = 32'h0C0F_0004;
  localparam logic [31:0] P_AID  = 32'hA1D0_0001;
  localparam logic [31:0] P_ID   = 32'h1D00_5EED;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [7:0] locked = 8'hFF, led;
  logic [NOSC*32-1:0] osc;
  int vectors = 0, fails = 0;

  // bench-side model
  logic [31:0] m_cfg0, m_cfg1, m_rtn, m_out, m_ctrl, m_osc [NOSC];
  logic [1:0]  m_stat;
  logic [7:0]  m_mask;

  always #2 clk = ~clk;

  board_ctrl_regs #(.CFG4_VAL(P_CFG4), .AID_VAL(P_AID), .ID_VAL(P_ID)) i_board_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .dll_locked_i(locked),
    .led_o(led), .osc_o(osc));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 v = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  // mask write whose access cycle also changes the lock inputs
  task automatic dll_wr_lock(input logic [7:0] mask, input logic [7:0] lk);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h100; pwdata = {mask, 24'h00FFFF};
    @(negedge clk); penable = 1; locked = lk;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a)
      12'h000: return m_cfg0;
      12'h004: return m_cfg1;
      12'h010: return P_CFG4;
      12'h0A0: return m_rtn;
      12'h0A4: return m_out;
      12'h0A8: return m_ctrl;
      12'h0AC: return {30'b0, m_stat};
      12'h100: return {m_mask, locked, 15'b0, &(locked | ~m_mask)};
      12'hFF8: return P_AID;
      12'hFFC: return P_ID;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_all(input string req);
    logic [31:0] v;
    logic [11:0] regs [10] = '{12'h000, 12'h004, 12'h00C, 12'h010, 12'h0A0, 12'h0A4,
                               12'h0A8, 12'h0AC, 12'h100, 12'hFFC};
    for (int i = 0; i < 10; i++) begin
      bus_rd(regs[i], v);
      check(req, v, exp_rd(regs[i]));
    end
    for (int k = 0; k < NOSC; k++) check(req, osc[k*32 +: 32], m_osc[k]);
    check(req, {24'b0, led}, {24'b0, m_cfg1[7:0]});
  endtask

  initial begin
    logic [31:0] v;
    m_cfg0 = 0; m_cfg1 = 0; m_rtn = 0; m_out = 0; m_ctrl = 32'h0010_0000; m_stat = 0;
    m_mask = 8'hFF;
    m_osc[0] = 32'd50000000; m_osc[1] = 32'd24576000; m_osc[2] = 32'd25000000;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check_all("R1");
    bus_rd(12'h100, v); check("R1", v, 32'hFFFF_0001);

    // R2 / R3 full aligned sweep
    for (int a = 0; a < 4096; a += 4) begin
      bus_rd(12'(a), v);
      check((a == 12 || a == 16 || a >= 12'hFF8) ? "R2" : "R3", v, exp_rd(12'(a)));
    end
    // R3 misaligned reads
    for (int a = 1; a < 4; a++) begin
      bus_rd(12'(12'h0A8 + a), v); check("R3", v, 32'h0);
      bus_rd(12'(12'hFFC + a), v); check("R3", v, 32'h0);
    end

    // R3 writes to every non-writable aligned offset and misaligned aliases
    for (int a = 0; a < 4096; a += 4) begin
      if (a != 0 && a != 4 && a != 12'h0A4 && a != 12'h0A8 && a != 12'h100)
        bus_wr(12'(a), 32'hFFFF_FFFF);
    end
    for (int a = 1; a < 4; a++) begin
      bus_wr(12'(a), 32'hFFFF_FFFF);
      bus_wr(12'(12'h004 + a), 32'hFFFF_FFFF);
      bus_wr(12'(12'h0A8 + a), 32'hFFFF_FFFF);
      bus_wr(12'(12'h100 + a), 32'h0000_0000);
    end
    check_all("R3");

    // R4 config words and LEDs
    for (int i = 0; i < 8; i++) begin
      m_cfg0 = 32'h0123_4567 * (i + 1);
      m_cfg1 = (32'h1 << i) | (32'hA500_0000 >> i);
      bus_wr(12'h000, m_cfg0);
      bus_wr(12'h004, m_cfg1);
      check("R4", {24'b0, led}, {24'b0, m_cfg1[7:0]});
      bus_rd(12'h000, v); check("R4", v, m_cfg0);
      bus_rd(12'h004, v); check("R4", v, m_cfg1);
    end

    // R5-R9 channel sweep: all function codes, in-range and out-of-range devices
    for (int f = 0; f < 64; f++) begin
      for (int di = 0; di < 5; di++) begin
        for (int w = 0; w < 2; w++) begin
          logic [11:0] dv;
          logic [31:0] cw;
          logic ok;
          string rq;
          dv = (di == 4) ? 12'hFFF : 12'(di);
          ok = (f == 1) && (dv < 3);
          m_out = 32'h5A00_0000 + 32'(f * 4096 + di * 16 + w);
          bus_wr(12'h0A4, m_out);
          cw = {1'b1, w[0], 4'hF, 6'(f), 8'hFF, dv};
          bus_wr(12'h0A8, cw);
          m_ctrl = cw & 32'h43F0_0FFF;
          m_stat = {~ok, 1'b1};
          if (ok && w == 1) m_osc[dv] = m_out;
          if (ok && w == 0) m_rtn = m_osc[dv];
          rq = !ok ? "R9" : (w == 1 ? "R7" : "R8");
          bus_rd(12'h0A8, v); check("R5", v, m_ctrl);
          bus_rd(12'h0AC, v); check(rq, v, {30'b0, m_stat});
          bus_rd(12'h0A0, v); check(rq, v, m_rtn);
          for (int k = 0; k < NOSC; k++) check(rq, osc[k*32 +: 32], m_osc[k]);
        end
      end
    end

    // R6 control write without go clears both flags
    bus_wr(12'h0A8, 32'h8000_0FFF);       // bad device: status 11
    bus_rd(12'h0AC, v); check("R9", v, 32'h3);
    bus_wr(12'h0A8, 32'h7FFF_FFFF);
    m_ctrl = 32'h43F0_0FFF; m_stat = 0;
    bus_rd(12'h0AC, v); check("R6", v, 32'h0);
    bus_rd(12'h0A8, v); check("R5", v, m_ctrl);

    // R10 mask write coinciding with lock input change
    for (int m = 0; m < 256; m++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] lk;
        case (p)
          0: lk = 8'h00;
          1: lk = 8'hFF;
          2: lk = 8'(m);
          default: lk = 8'(m) ^ 8'(1 << (m % 8));
        endcase
        dll_wr_lock(8'(m), lk);
        m_mask = 8'(m);
        bus_rd(12'h100, v);
        check("R10", v, {8'(m), lk, 15'b0, &(lk | ~8'(m))});
      end
    end
    check_all("R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule